// File: doc/BRIEF.md
# Pool-Constrained Scan Ordering Engine

This engine computes an ordering of `N` scan cells, one chain position at a time. Each cell carries a class bit taken from a captured response, so the cells fall into a zero pool and a one pool. A target bit vector and an index sequence are also supplied. Together they fix the pool that every position must draw from: position `i` uses the pool named by `tgt_bits[q_seq[i]]`. Within that pool the engine takes the unplaced cell with the lowest switching cost to the cell placed just before. The chain therefore follows a greedy low-transition path while spelling out a chosen bit pattern.

Before a run, software or a loader writes the pairwise cost table into on-chip storage through a simple write port. Each cost is an accumulated bit-difference count between two cells over a test set. A one-cycle `start` latches the class, target and index inputs. The engine then looks at one candidate per clock and reports every placement as a one-cycle record of position and cell index. It raises `done` with the final placement, or with `err` if some position finds its pool empty.

Top module: `sco_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `place_valid` are all low.
- R2: For every position after the first, the placed cell has the smallest cost entry `cost[prev*N + c]` among unplaced cells `c` whose class bit equals the required pool. `prev` is the cell placed at the previous position, and the required pool for position `i` is `tgt_bits[q_seq[i*IW +: IW]]`.
- R3: Position 0 ignores the cost table and takes the lowest-index cell whose class bit equals the pool required for position 0.
- R4: When several eligible cells share the minimum cost, the one with the lowest index is placed.
- R5: Each placed cell differs from every cell placed earlier in the run, and its class bit equals the pool required for its position. A consistent target vector (same number of ones as the class bits) yields exactly `N` placements.
- R6: Each placement is a one-cycle `place_valid` pulse, and `place_pos` counts 0, 1, 2 and so on. The k-th placement (counting from 1) appears k*(N+2) clock edges after the edge that accepted `start`.
- R7: `busy` is high from the edge that accepts `start` until the run ends. `done` is a single-cycle pulse that coincides with the last placement, or with the error. `busy` is low in the cycle after `done`.
- R8: If the required pool has no unplaced cell at some position, `err` rises together with `done` and no placement is emitted for that position. `err` then stays high until the next accepted `start`.
- R9: A `start` pulse while `busy` is ignored. The class, target and index inputs are sampled only when `start` is accepted, so changing them during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cost_we | input | 1 | Cost table write enable |
| cost_waddr | input | AW | Cost table address, row*N + column |
| cost_wdata | input | CW | Cost value to write |
| cls_bits | input | N | Class bit per cell |
| tgt_bits | input | N | Target pattern indexed through the sequence |
| q_seq | input | N*IW | Index per position, position i at bits i*IW |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Required pool was empty |
| place_valid | output | 1 | Placement record valid |
| place_pos | output | IW | Position being filled |
| place_cell | output | IW | Cell placed at that position |

## Verification
The bound checker watches the handshake and the placement stream on every cycle. It checks the reset state and the single-cycle `done`. It checks that positions arrive in order, with exactly N+2 cycles between placements, that no cell is placed twice, and that an error always coincides with `done`. Whether the chosen cell really is the cheapest eligible one, and whether ties go to the lowest index, can only be shown by the bench scenarios. Those scenarios compare every placement against an independent greedy model under equal-cost tables, random symmetric tables, an inconsistent target and inputs disturbed mid-run.

// File: rtl/sco_pkg.sv
package sco_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_COMMIT = 2'd3
  } sco_state_e;
endpackage

// File: rtl/sco_cost_ram.sv
// Pairwise cost store: one write port, one registered read port.
module sco_cost_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sco_pool_mask.sv
// Tracks placed cells and flags which cells are still eligible for the pool.
module sco_pool_mask #(
  parameter int N   = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          set,
  input  logic [IW-1:0] set_idx,
  input  logic [N-1:0]  cls,
  input  logic          phi,
  output logic [N-1:0]  elig
);
  logic [N-1:0] placed;

  for (genvar g = 0; g < N; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst || clr)                      placed[g] <= 1'b0;
      else if (set && set_idx == IW'(g))   placed[g] <= 1'b1;
    end
    assign elig[g] = !placed[g] && (cls[g] == phi);
  end
endmodule

// File: rtl/sco_argmin.sv
// Running minimum over a candidate stream; strict compare keeps the earliest index on ties.
module sco_argmin #(
  parameter int N   = 8,
  parameter int CW  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [IW-1:0] in_idx,
  input  logic [CW-1:0] in_cost,
  output logic          found,
  output logic [IW-1:0] best_idx
);
  logic [CW-1:0] best_cost;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      found     <= 1'b0;
      best_idx  <= '0;
      best_cost <= '0;
    end else if (in_valid && (!found || in_cost < best_cost)) begin
      found     <= 1'b1;
      best_idx  <= in_idx;
      best_cost <= in_cost;
    end
  end
endmodule

// File: rtl/sco_engine.sv
// Greedy scan-order engine: one candidate per clock, N+2 cycles per position.
module sco_engine
  import sco_pkg::*;
#(
  parameter int N   = 8,
  parameter int CW  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int AW = $clog2(N * N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cost_we,
  input  logic [AW-1:0]   cost_waddr,
  input  logic [CW-1:0]   cost_wdata,
  input  logic [N-1:0]    cls_bits,
  input  logic [N-1:0]    tgt_bits,
  input  logic [N*IW-1:0] q_seq,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            place_valid,
  output logic [IW-1:0]   place_pos,
  output logic [IW-1:0]   place_cell
);
  localparam logic [AW-1:0] N_A  = AW'(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  sco_state_e state;

  logic [N-1:0]    cls_r, tgt_r;
  logic [N*IW-1:0] q_r;
  logic [IW-1:0]   pos, cand, prev;

  // candidate pipeline aligned with the registered RAM read
  logic            pv_d, first_d;
  logic [IW-1:0]   pidx_d;

  logic [CW-1:0]   rd_cost;
  logic [AW-1:0]   rd_addr;
  logic [N-1:0]    elig;
  logic [IW-1:0]   q_cur;
  logic            phi;
  logic            accept, mask_clr, am_clr, commit_ok;
  logic            am_found;
  logic [IW-1:0]   am_best;

  assign accept    = (state == ST_IDLE) && start;
  assign mask_clr  = accept;
  assign am_clr    = accept || (state == ST_COMMIT);
  assign commit_ok = (state == ST_COMMIT) && am_found;

  assign q_cur   = q_r[int'(pos)*IW +: IW];
  assign phi     = (int'(q_cur) < N) ? tgt_r[q_cur] : 1'b0;
  assign rd_addr = AW'(prev) * N_A + AW'(cand);

  sco_cost_ram #(.DW(CW), .DEPTH(N * N)) u_ram (
    .clk   (clk),
    .we    (cost_we),
    .waddr (cost_waddr),
    .wdata (cost_wdata),
    .raddr (rd_addr),
    .rdata (rd_cost)
  );

  sco_pool_mask #(.N(N)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .clr     (mask_clr),
    .set     (commit_ok),
    .set_idx (am_best),
    .cls     (cls_r),
    .phi     (phi),
    .elig    (elig)
  );

  sco_argmin #(.N(N), .CW(CW)) u_min (
    .clk      (clk),
    .rst      (rst),
    .clr      (am_clr),
    .in_valid (pv_d),
    .in_idx   (pidx_d),
    .in_cost  (first_d ? '0 : rd_cost),
    .found    (am_found),
    .best_idx (am_best)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cls_r       <= '0;
      tgt_r       <= '0;
      q_r         <= '0;
      pos         <= '0;
      cand        <= '0;
      prev        <= '0;
      pv_d        <= 1'b0;
      first_d     <= 1'b0;
      pidx_d      <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      place_valid <= 1'b0;
      place_pos   <= '0;
      place_cell  <= '0;
    end else begin
      done        <= 1'b0;
      place_valid <= 1'b0;
      pv_d        <= (state == ST_SCAN) && elig[cand];
      pidx_d      <= cand;
      first_d     <= (pos == '0);

      unique case (state)
        ST_IDLE: begin
          if (start) begin
            cls_r <= cls_bits;
            tgt_r <= tgt_bits;
            q_r   <= q_seq;
            pos   <= '0;
            cand  <= '0;
            prev  <= '0;
            busy  <= 1'b1;
            err   <= 1'b0;
            state <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          cand <= cand + 1'b1;
          if (cand == LAST) state <= ST_DRAIN;
        end
        ST_DRAIN: state <= ST_COMMIT;
        ST_COMMIT: begin
          if (!am_found) begin
            err   <= 1'b1;
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            place_valid <= 1'b1;
            place_pos   <= pos;
            place_cell  <= am_best;
            prev        <= am_best;
            if (pos == LAST) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              pos   <= pos + 1'b1;
              cand  <= '0;
              state <= ST_SCAN;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sco_engine_chk.sv
module sco_engine_chk #(
  parameter int N   = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int GW = $clog2(N + 3) + 2
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          place_valid,
  input logic [IW-1:0] place_pos,
  input logic [IW-1:0] place_cell
);
  logic [N-1:0]  seen;
  logic [IW:0]   pcnt;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
      pcnt <= '0;
      gap  <= '0;
    end else if (start && !busy) begin
      seen <= '0;
      pcnt <= '0;
      gap  <= '0;
    end else begin
      if (place_valid) begin
        seen[place_cell] <= 1'b1;
        pcnt <= pcnt + 1'b1;
        gap  <= GW'(1);
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && !err && !place_valid));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  a_r6_place_in_run: assert property (@(posedge clk) disable iff (rst)
    (place_valid && !done) |-> busy);

  a_r6_pos_order: assert property (@(posedge clk) disable iff (rst)
    place_valid |-> ({1'b0, place_pos} == pcnt));

  a_r6_spacing: assert property (@(posedge clk) disable iff (rst)
    place_valid |-> (gap == GW'(N + 2)));

  a_r5_unique_cell: assert property (@(posedge clk) disable iff (rst)
    place_valid |-> !seen[place_cell]);

  a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (done && !place_valid));
endmodule

bind sco_engine sco_engine_chk #(.N(N)) u_chk (.*);

// File: tb/sco_engine_tb.sv
module sco_engine_tb;
  localparam int N     = 8;
  localparam int CW    = 8;
  localparam int IW    = $clog2(N);
  localparam int AW    = $clog2(N * N);
  localparam int CLK_P = 10;
  localparam int PER   = N + 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cost_we = 1'b0;
  logic [AW-1:0]   cost_waddr = '0;
  logic [CW-1:0]   cost_wdata = '0;
  logic [N-1:0]    cls_bits = '0;
  logic [N-1:0]    tgt_bits = '0;
  logic [N*IW-1:0] q_seq = '0;
  logic            start = 1'b0;
  logic            busy, done, err, place_valid;
  logic [IW-1:0]   place_pos, place_cell;

  always #(CLK_P/2) clk = ~clk;

  sco_engine #(.N(N), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .cost_we(cost_we), .cost_waddr(cost_waddr),
    .cost_wdata(cost_wdata), .cls_bits(cls_bits), .tgt_bits(tgt_bits),
    .q_seq(q_seq), .start(start), .busy(busy), .done(done), .err(err),
    .place_valid(place_valid), .place_pos(place_pos), .place_cell(place_cell)
  );

  int checks = 0;
  int errors = 0;
  int cm [N][N];
  logic [N-1:0] cls_v, tgt_v;
  int qv [N];
  int exp_cell [N];
  int exp_n;
  bit exp_err;
  int got_cell [N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent greedy model
  function automatic void model();
    bit used [N];
    int prev = 0;
    for (int c = 0; c < N; c++) used[c] = 1'b0;
    exp_n = 0;
    exp_err = 1'b0;
    for (int i = 0; i < N; i++) begin
      bit ph = tgt_v[qv[i]];
      int best = -1;
      int bc = 0;
      for (int c = 0; c < N; c++) begin
        if (!used[c] && cls_v[c] == ph) begin
          int cc = (i == 0) ? 0 : cm[prev][c];
          if (best < 0 || cc < bc) begin
            best = c;
            bc = cc;
          end
        end
      end
      if (best < 0) begin
        exp_err = 1'b1;
        return;
      end
      exp_cell[i] = best;
      used[best] = 1'b1;
      prev = best;
      exp_n++;
    end
  endfunction

  task automatic load_cost();
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        @(negedge clk);
        cost_we    = 1'b1;
        cost_waddr = AW'(r * N + c);
        cost_wdata = CW'(cm[r][c]);
      end
    end
    @(negedge clk);
    cost_we = 1'b0;
  endtask

  task automatic run_case(input string ctag, input bit poke);
    int cnt = 0;
    int got = 0;
    int done_cnt = 0;
    int mism = 0;
    bit seen_done = 1'b0;
    bit err_s = 1'b0;
    bit uniq_ok = 1'b1;
    model();
    cls_bits = cls_v;
    tgt_bits = tgt_v;
    for (int i = 0; i < N; i++) q_seq[i*IW +: IW] = IW'(qv[i]);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    while (!seen_done && cnt < 4 * N * PER) begin
      @(negedge clk);
      cnt++;
      if (place_valid) begin
        if (got < exp_n) begin
          chk(int'(place_cell) == exp_cell[got], (got == 0) ? "R3 first cell" : ctag,
              int'(place_cell), exp_cell[got]);
          if (int'(place_cell) != exp_cell[got]) mism++;
          got_cell[got] = int'(place_cell);
        end else begin
          chk(1'b0, "R5 extra placement", got, exp_n);
        end
        chk(int'(place_pos) == got, "R6 position index", int'(place_pos), got);
        chk(cnt == (got + 1) * PER, "R6 placement cycle", cnt, (got + 1) * PER);
        if (cnt != (got + 1) * PER) mism++;
        got++;
      end
      if (done) begin
        seen_done = 1'b1;
        done_cnt  = cnt;
        err_s     = err;
      end
      if (poke && cnt == 3) begin
        start    = 1'b1;
        cls_bits = ~cls_v;
        tgt_bits = ~tgt_v;
      end
      if (poke && cnt == 4) start = 1'b0;
    end
    chk(seen_done, "R7 done reached", int'(seen_done), 1);
    chk(err_s == exp_err, "R8 error flag", int'(err_s), int'(exp_err));
    chk(got == exp_n, "R5 placement count", got, exp_n);
    chk(done_cnt == (exp_n + (exp_err ? 1 : 0)) * PER, "R7 done cycle",
        done_cnt, (exp_n + (exp_err ? 1 : 0)) * PER);
    for (int i = 0; i < got && i < N; i++) begin
      if (cls_v[got_cell[i]] != tgt_v[qv[i]]) uniq_ok = 1'b0;
      for (int j = 0; j < i; j++) if (got_cell[j] == got_cell[i]) uniq_ok = 1'b0;
    end
    chk(uniq_ok, "R5 distinct cells in required pool", int'(uniq_ok), 1);
    if (poke) chk(mism == 0, "R9 run unaffected by mid-run inputs", mism, 0);
    @(negedge clk);
    chk(!busy && !done, "R7 idle after end", int'(busy), 0);
    if (exp_err) chk(err == 1'b1, "R8 error held", int'(err), 1);
  endtask

  task automatic rand_case();
    int n1 = 0;
    for (int r = 0; r < N; r++) begin
      cm[r][r] = 0;
      for (int c = r + 1; c < N; c++) begin
        int v = int'($urandom % 8);
        cm[r][c] = v;
        cm[c][r] = v;
      end
    end
    cls_v = N'($urandom);
    for (int i = 0; i < N; i++) if (cls_v[i]) n1++;
    tgt_v = '0;
    for (int i = 0; i < N; i++) tgt_v[i] = (i >= N - n1);
    for (int i = N - 1; i > 0; i--) begin
      int k = int'($urandom % (i + 1));
      logic t = tgt_v[i];
      tgt_v[i] = tgt_v[k];
      tgt_v[k] = t;
    end
    for (int i = 0; i < N; i++) qv[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      int k = int'($urandom % (i + 1));
      int t = qv[i];
      qv[i] = qv[k];
      qv[k] = t;
    end
  endtask

  bit finished = 1'b0;

  initial begin
    void'($urandom(32'd1107));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !place_valid, "R1 reset state",
        int'({busy, done, err, place_valid}), 0);

    // equal costs: ties resolve to lowest index
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) cm[r][c] = 3;
    load_cost();
    cls_v = 8'b1010_1010;
    tgt_v = cls_v;
    for (int i = 0; i < N; i++) qv[i] = i;
    run_case("R4 tie to lowest index", 1'b0);

    // strictly ordered costs, reversed sequence
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) cm[r][c] = (r == c) ? 0 : ((r * 5 + c * 3) % 11) + 1;
    load_cost();
    cls_v = 8'b0110_0011;
    tgt_v = 8'b1001_0110;
    for (int i = 0; i < N; i++) qv[i] = N - 1 - i;
    run_case("R2 nearest cell", 1'b0);

    // inconsistent target: pool 1 runs dry at position 4
    cls_v = 8'h0F;
    tgt_v = 8'hFF;
    for (int i = 0; i < N; i++) qv[i] = i;
    run_case("R8 cells before empty pool", 1'b0);

    // start and inputs disturbed during a run
    cls_v = 8'b1100_1010;
    tgt_v = 8'b0101_1100;
    for (int i = 0; i < N; i++) qv[i] = (i * 3) % N;
    run_case("R9 cell with disturbed inputs", 1'b1);

    for (int k = 0; k < 10; k++) begin
      rand_case();
      load_cost();
      run_case("R2 nearest cell random", 1'b0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule